// File: doc/BRIEF.md
# Real-Output Transform Frame Builder

This block prepares the input of a 64-point inverse transform so that the transform produces a purely real waveform. Such a waveform can drive the intensity of a light source directly. Complex data symbols arrive on an AXI4-Stream slave, and one frame's worth of them is held in a small store. The block then emits all 64 bins in index order on an AXI4-Stream master. The zero-frequency bin and the mid-band (Nyquist) bin are forced to zero. The lower half carries the data symbols. Each upper bin is the complex conjugate of its mirror partner in the lower half, so X[64-k] = conj(X[k]).

The same module, built with the `REMOVE` parameter set, serves the receive side. It watches the 64 bins leaving the forward transform and forwards only the data bins. The zero-frequency bin and the mirrored upper half are accepted and discarded. The module never buffers on that path.

Top module: `hermitian_frame_builder`

## Requirements
- R1: After reset the builder shows `m_tvalid` low and `s_tready` high, so it is ready to capture a new frame.
- R2: The builder accepts exactly 31 input symbols per frame. It shows no output until all 31 have been captured, and it holds `s_tready` low for as long as output is in progress.
- R3: Output bin 0 and output bin 32 are both all-zero words.
- R4: Output bins 1 to 31 carry the captured symbols in arrival order: bin k holds the k-th symbol of the frame, counting from 1.
- R5: Output bin k, for k from 33 to 63, carries the conjugate of bin 64-k. Its I half `[31:16]` is unchanged and its Q half `[15:0]` is negated in two's complement (default W=16, word = {I, Q}).
- R6: The negation saturates. A Q value of 16'h8000 becomes 16'h7FFF, and 16'h7FFF becomes 16'h8001. The I half is never altered, even when it is 16'h8000.
- R7: In builder mode `m_tlast` is high on bin 63 only.
- R8: While `m_tvalid` is high and `m_tready` is low, `m_tdata` and `m_tlast` stay unchanged until the bin is accepted.
- R9: After bin 63 is accepted the builder returns to capture. Consecutive frames are independent, and each frame's upper half mirrors its own data.
- R10: In remover mode, of each 64 input bins only bins 1 to 31 are forwarded, unchanged and in order, with `m_tlast` on bin 31. Bins 0 and 32 to 63 are accepted with `s_tready` high whatever `m_tready` is, and they never raise `m_tvalid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| s_tvalid | input | 1 | Input symbol or bin valid |
| s_tready | output | 1 | Block can take the input word |
| s_tdata | input | 2*W | Input word {I, Q}, two's complement |
| m_tvalid | output | 1 | Output word valid |
| m_tready | input | 1 | Downstream can take the output word |
| m_tdata | output | 2*W | Output word {I, Q} |
| m_tlast | output | 1 | Last word of the output frame |

## Verification
The bench targets the saturating corner by placing 16'h8000 and 16'h7FFF in Q, and 16'h8000 in I, in the first frame. A design that negated without clamping would send 16'h8000 back in the mirror bin, and one that conjugated the wrong half would corrupt I. Mirror addressing is checked on every upper bin across several random frames. An off-by-one in the mirror index would show up as a shifted or a wrong symbol near bins 33 and 63. Runs of zero ready on the output check that a held bin does not advance. On the receive instance, a dropped bin arrives while downstream is stalled, so a remover that tied its ready to the output would hang or leak conjugate bins.

// File: rtl/hsym_pkg.sv
`timescale 1ns/1ps
package hsym_pkg;
   typedef enum logic {HS_FILL = 1'b0, HS_SEND = 1'b1} hs_phase_e;
endpackage

// File: rtl/hsym_wrap_counter.sv
`timescale 1ns/1ps
module hsym_wrap_counter #(
   parameter int LIMIT = 64,
   parameter int CW    = $clog2(LIMIT)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   output logic [CW-1:0] cnt,
   output logic          at_end
);
   assign at_end = (cnt == CW'(LIMIT-1));

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt <= '0;
      else if (en)   cnt <= at_end ? '0 : cnt + 1'b1;
   end
endmodule

// File: rtl/hsym_symbol_store.sv
`timescale 1ns/1ps
module hsym_symbol_store #(
   parameter int DEPTH = 31,
   parameter int DW    = 32,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end
   assign rdata = mem[raddr];
endmodule

// File: rtl/hsym_conj.sv
`timescale 1ns/1ps
module hsym_conj #(
   parameter int W = 16
) (
   input  logic [2*W-1:0] din,
   output logic [2*W-1:0] dout
);
   localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
   localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};
   logic [W-1:0] q_in, q_neg;

   assign q_in  = din[W-1:0];
   assign q_neg = (q_in == MOST_NEG) ? MOST_POS : (~q_in + 1'b1);
   assign dout  = {din[2*W-1:W], q_neg};
endmodule

// File: rtl/hermitian_frame_builder.sv
`timescale 1ns/1ps
module hermitian_frame_builder
   import hsym_pkg::*;
#(
   parameter int NFFT   = 64,
   parameter int W      = 16,
   parameter bit REMOVE = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         s_tvalid,
   output logic         s_tready,
   input  logic [2*W-1:0] s_tdata,
   output logic         m_tvalid,
   input  logic         m_tready,
   output logic [2*W-1:0] m_tdata,
   output logic         m_tlast
);
   localparam int HALF  = NFFT / 2;
   localparam int NDATA = HALF - 1;
   localparam int BW    = $clog2(NFFT);
   localparam int DAW   = $clog2(NDATA);
   localparam int DW    = 2 * W;

   if (NFFT < 8 || (NFFT & (NFFT - 1)) != 0) begin : g_bad_nfft
      $error("NFFT must be a power of two of at least 8");
   end
   if (W < 2) begin : g_bad_w
      $error("W must be at least 2");
   end

   if (!REMOVE) begin : g_build
      hs_phase_e       phase;
      logic [BW-1:0]   bin;
      logic            bin_end;
      logic [DAW-1:0]  wr_idx;
      logic            wr_end;
      logic [BW-1:0]   mirror;
      logic [DAW-1:0]  rd_idx;
      logic [DW-1:0]   rd_word, conj_word;
      logic            in_fire, out_fire, null_bin;

      assign s_tready = (phase == HS_FILL);
      assign m_tvalid = (phase == HS_SEND);
      assign in_fire  = s_tvalid && s_tready;
      assign out_fire = m_tvalid && m_tready;

      hsym_wrap_counter #(.LIMIT(NDATA), .CW(DAW)) u_wr_cnt (
         .clk(clk), .rst_n(rst_n), .en(in_fire), .cnt(wr_idx), .at_end(wr_end));

      hsym_wrap_counter #(.LIMIT(NFFT), .CW(BW)) u_bin_cnt (
         .clk(clk), .rst_n(rst_n), .en(out_fire), .cnt(bin), .at_end(bin_end));

      always_ff @(posedge clk) begin
         if (!rst_n) phase <= HS_FILL;
         else if (phase == HS_FILL && in_fire && wr_end)    phase <= HS_SEND;
         else if (phase == HS_SEND && out_fire && bin_end)  phase <= HS_FILL;
      end

      assign null_bin = (bin == '0) || (bin == BW'(HALF));

      always_comb begin
         if (bin < BW'(HALF)) mirror = bin - 1'b1;
         else                 mirror = BW'(NFFT - 1) - bin;
         rd_idx = null_bin ? '0 : mirror[DAW-1:0];
      end

      hsym_symbol_store #(.DEPTH(NDATA), .DW(DW), .AW(DAW)) u_store (
         .clk(clk), .we(in_fire), .waddr(wr_idx), .wdata(s_tdata),
         .raddr(rd_idx), .rdata(rd_word));

      hsym_conj #(.W(W)) u_conj (.din(rd_word), .dout(conj_word));

      always_comb begin
         if (null_bin)               m_tdata = '0;
         else if (bin < BW'(HALF))   m_tdata = rd_word;
         else                        m_tdata = conj_word;
      end
      assign m_tlast = m_tvalid && bin_end;
   end else begin : g_remove
      logic [BW-1:0] bin;
      logic          bin_end;
      logic          keep;

      hsym_wrap_counter #(.LIMIT(NFFT), .CW(BW)) u_bin_cnt (
         .clk(clk), .rst_n(rst_n), .en(s_tvalid && s_tready),
         .cnt(bin), .at_end(bin_end));

      assign keep     = (bin != '0) && (bin < BW'(HALF));
      assign s_tready = keep ? m_tready : 1'b1;
      assign m_tvalid = s_tvalid && keep;
      assign m_tdata  = s_tdata;
      assign m_tlast  = keep && (bin == BW'(HALF - 1));
   end
endmodule

// File: rtl/hsym_checker.sv
`timescale 1ns/1ps
module hsym_checker #(
   parameter int NFFT   = 64,
   parameter int W      = 16,
   parameter bit REMOVE = 1'b0
) (
   input logic         clk,
   input logic         rst_n,
   input logic         s_tvalid,
   input logic         s_tready,
   input logic         m_tvalid,
   input logic         m_tready,
   input logic [2*W-1:0] m_tdata,
   input logic         m_tlast
);
   localparam int HALF  = NFFT / 2;
   localparam int NDATA = HALF - 1;
   localparam int NOUT  = REMOVE ? NDATA : NFFT;
   localparam int CW    = $clog2(NFFT) + 1;

   logic [CW-1:0] in_cnt, out_cnt;
   logic in_fire, out_fire;
   assign in_fire  = s_tvalid && s_tready;
   assign out_fire = m_tvalid && m_tready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_cnt  <= '0;
         out_cnt <= '0;
      end else begin
         if (REMOVE) begin
            if (in_fire) in_cnt <= (in_cnt == CW'(NFFT-1)) ? '0 : in_cnt + 1'b1;
         end else begin
            if (in_fire)                     in_cnt <= in_cnt + 1'b1;
            else if (out_fire && m_tlast)    in_cnt <= '0;
         end
         if (out_fire) out_cnt <= m_tlast ? '0 : out_cnt + 1'b1;
      end
   end

   assert_wait_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!REMOVE && m_tvalid) |-> (in_cnt == CW'(NDATA) && !s_tready));

   assert_dc_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!REMOVE && m_tvalid && (out_cnt == '0 || out_cnt == CW'(HALF))) |-> (m_tdata == '0));

   assert_last_pos_R7: assert property (@(posedge clk) disable iff (!rst_n)
      m_tvalid |-> (m_tlast == (out_cnt == CW'(NOUT-1))));

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!REMOVE && m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

   assert_drop_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (REMOVE && s_tvalid && (in_cnt == '0 || in_cnt >= CW'(HALF))) |-> (s_tready && !m_tvalid));
endmodule

bind hermitian_frame_builder hsym_checker #(.NFFT(NFFT), .W(W), .REMOVE(REMOVE)) u_hsym_chk (
   .clk(clk), .rst_n(rst_n), .s_tvalid(s_tvalid), .s_tready(s_tready),
   .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata), .m_tlast(m_tlast));

// File: tb/hermitian_frame_builder_test.sv
`timescale 1ns/1ps
module hermitian_frame_builder_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   // builder instance
   logic s_tvalid = 1'b0, s_tready, m_tvalid, m_tready = 1'b0, m_tlast;
   logic [31:0] s_tdata = '0, m_tdata;
   // remover instance
   logic r_s_tvalid = 1'b0, r_s_tready, r_m_tvalid, r_m_tready = 1'b0, r_m_tlast;
   logic [31:0] r_s_tdata = '0, r_m_tdata;

   hermitian_frame_builder #(.NFFT(64), .W(16), .REMOVE(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata),
      .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata), .m_tlast(m_tlast));

   hermitian_frame_builder #(.NFFT(64), .W(16), .REMOVE(1'b1)) uut_rx (
      .clk(clk), .rst_n(rst_n), .s_tvalid(r_s_tvalid), .s_tready(r_s_tready), .s_tdata(r_s_tdata),
      .m_tvalid(r_m_tvalid), .m_tready(r_m_tready), .m_tdata(r_m_tdata), .m_tlast(r_m_tlast));

   int checks = 0, fails = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] conj_exp(input logic [31:0] d);
      logic [15:0] q;
      q = d[15:0];
      return {d[31:16], (q == 16'h8000) ? 16'h7fff : (16'h0000 - q)};
   endfunction

   logic [31:0] fr [31];

   function automatic logic [31:0] bin_exp(input int b);
      if (b == 0 || b == 32) return 32'h0;
      if (b < 32) return fr[b-1];
      return conj_exp(fr[64-b-1]);
   endfunction

   function automatic logic [31:0] directed_sym(input int k);
      logic [15:0] i, q;
      i = 16'(k * 257 - 3000);
      q = 16'(k * 1000 + 5);
      if (k == 0) q = 16'h8000;
      if (k == 1) q = 16'h7fff;
      if (k == 2) q = 16'h0000;
      if (k == 3) i = 16'h8000;
      if (k == 30) begin i = 16'h7fff; q = 16'h8000; end
      return {i, q};
   endfunction

   initial begin
      #(20 * 150000);
      fails++; checks++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      int gen_cnt, widx, obin, frames;
      bit have_pend, hold_pend, start_seen;
      logic [31:0] pend, hold_data;
      logic hold_last;
      string tag;

      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      #1;
      chk(m_tvalid == 1'b0, "R1 m_tvalid after reset", {31'b0, m_tvalid}, 32'h0);
      chk(s_tready == 1'b1, "R1 s_tready after reset", {31'b0, s_tready}, 32'h1);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(m_tvalid == 1'b0 && s_tready == 1'b1, "R1 idle after reset release",
          {30'b0, m_tvalid, s_tready}, 32'h1);

      // ---------------- builder ----------------
      gen_cnt = 0; widx = 0; obin = 0; frames = 0;
      have_pend = 0; hold_pend = 0; start_seen = 0;
      for (int cyc = 0; cyc < 20000 && frames < 6; cyc++) begin
         @(negedge clk);
         if (!have_pend) begin
            pend = (gen_cnt < 31) ? directed_sym(gen_cnt) : $urandom;
            gen_cnt++;
            have_pend = 1;
         end
         s_tvalid = ($urandom % 4) != 0;
         s_tdata  = pend;
         if ((cyc % 150) >= 40 && (cyc % 150) < 48) m_tready = 1'b0;
         else m_tready = ($urandom % 3) != 0;
         #1;
         if (hold_pend)
            chk(m_tvalid && m_tdata == hold_data && m_tlast == hold_last,
                "R8 held bin changed", m_tdata, hold_data);
         hold_pend = m_tvalid && !m_tready;
         hold_data = m_tdata;
         hold_last = m_tlast;
         if (m_tvalid && !start_seen) begin
            start_seen = 1;
            chk(widx == 31 && !s_tready, "R2 output before full frame", 32'(widx), 32'd31);
         end
         if (s_tvalid && s_tready) begin
            if (widx < 31) fr[widx] = s_tdata;
            widx++;
            have_pend = 0;
         end
         if (m_tvalid && m_tready) begin
            if (obin == 0 || obin == 32) tag = "R3 null bin";
            else if (obin < 32)          tag = "R4 data bin";
            else if (fr[63-obin][15:0] == 16'h8000 || fr[63-obin][31:16] == 16'h8000)
                                         tag = "R6 saturating mirror bin";
            else                         tag = "R5 mirror bin";
            if (frames > 0) tag = {tag, " R9 later frame"};
            chk(m_tdata == bin_exp(obin), tag, m_tdata, bin_exp(obin));
            chk(m_tlast == (obin == 63), "R7 tlast position", {31'b0, m_tlast}, {31'b0, obin == 63});
            if (obin == 63) begin
               obin = 0; widx = 0; frames++; start_seen = 0;
            end else obin++;
         end
      end
      chk(frames == 6, "R9 frame count", 32'(frames), 32'd6);
      s_tvalid = 1'b0;
      m_tready = 1'b0;

      // ---------------- remover ----------------
      begin
         int ibin, outs, rframes;
         bit rhave;
         logic [31:0] rpend;
         ibin = 0; outs = 0; rframes = 0; rhave = 0;
         for (int cyc = 0; cyc < 20000 && rframes < 4; cyc++) begin
            @(negedge clk);
            if (!rhave) begin rpend = $urandom; rhave = 1; end
            r_s_tvalid = ($urandom % 4) != 0;
            r_s_tdata  = rpend;
            if ((cyc % 100) < 12) r_m_tready = 1'b0;
            else r_m_tready = ($urandom % 3) != 0;
            #1;
            if (r_s_tvalid) begin
               if (ibin == 0 || ibin >= 32) begin
                  chk(r_s_tready && !r_m_tvalid, "R10 dropped bin not accepted or leaked",
                      {30'b0, r_s_tready, r_m_tvalid}, 32'h2);
               end else begin
                  chk(r_m_tvalid && r_s_tready == r_m_tready, "R10 data bin handshake",
                      {30'b0, r_m_tvalid, r_s_tready}, {30'b0, 1'b1, r_m_tready});
                  if (r_m_tvalid && r_m_tready) begin
                     chk(r_m_tdata == rpend, "R10 forwarded data", r_m_tdata, rpend);
                     chk(r_m_tlast == (ibin == 31), "R10 tlast on bin 31",
                         {31'b0, r_m_tlast}, {31'b0, ibin == 31});
                     outs++;
                  end
               end
               if (r_s_tready) begin
                  rhave = 0;
                  if (ibin == 63) begin ibin = 0; rframes++; end
                  else ibin++;
               end
            end
         end
         chk(outs == 4 * 31, "R10 forwarded count", 32'(outs), 32'(4 * 31));
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule